// File: doc/BRIEF.md
# System Clock Mode Controller

This block produces the CPU clock enable for a small 8-bit controller. The enable comes from one of two oscillator tick streams: the main oscillator's ticks feed a fast and a medium rate, and a slow sub-clock's ticks feed a low rate. A 2-bit mode field chooses the rate. The block also holds the request latches for wait and stop. A wait only gates the CPU enable. A stop also halts the main oscillator until a wake request arrives.

A small control register adds two hardware sequences. The first is an automatic return from low-speed to middle-speed mode. Software arms it with a single write. The block then restarts the main oscillator, counts a selectable number of low-speed machine cycles and rewrites the mode field itself. The second is a stabilisation countdown after a stop is released. A prescaler and timer preload keep the CPU enable gated while the oscillator settles. A control bit can skip the preload, and the CPU is then released on the first count-source tick.

Top module: `sysclk_mode_ctrl`

## Requirements
- R1: After reset the mode register reads 0x40 (mode 01 = middle speed, main oscillator running), the control register reads 0x00, `main_osc_en` is 1 and `clk_halted` is 0.
- R2: The mode register bits 7:6 set the rate. Code 00 gives one `cpu_ce` pulse every 2 main ticks. Codes 01 and 11 give one pulse every 8 main ticks. Code 10 gives one pulse every 2 sub ticks. Every write to the mode register restarts the divider, so the first pulse after a write comes only after a full period.
- R3: Mode register bit 5 stops the main oscillator. While it is 1, `main_osc_en` is 0 and main ticks are ignored. Mode register bits 4:0 read as 0.
- R4: In the control register, bit 0 skips the stabilisation preload, bit 1 enables the automatic switch, bit 2 selects the short wait and bit 3 is the switch-in-progress (start) flag. Bits 7:4 read as 0.
- R5: A switch starts only on a control write that has both bit 3 and bit 1 set while the mode is 10. Otherwise bit 3 reads 0 and neither the mode nor the main oscillator changes.
- R6: An accepted switch clears the main-stop bit at once. After 7 low-speed machine cycles (bit 2 = 0) or 5 (bit 2 = 1), the mode field becomes 01 and bit 3 returns to 0.
- R7: A wait request holds `cpu_ce` at 0 and sets `clk_halted`, while the oscillators keep running. A wake request resumes the clock.
- R8: A stop request drives `main_osc_en` to 0, holds `cpu_ce` at 0 and sets `clk_halted`.
- R9: With control bit 0 = 0, the CPU stays halted after a wake from stop for 256 count-source ticks. A count-source tick is every 16th tick of the selected oscillator, and this count restarts at stop entry. That makes 4096 oscillator ticks.
- R10: With control bit 0 = 1, the CPU is released on the first count-source tick after the wake, which is 16 oscillator ticks.
- R11: Stop and wait requests are ignored while the clock is already halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock that samples all tick strobes |
| rst_n | input | 1 | Active-low asynchronous reset |
| main_tick | input | 1 | One-cycle strobe per main oscillator period |
| sub_tick | input | 1 | One-cycle strobe per sub-clock period |
| stop_req | input | 1 | Stop instruction executed |
| wait_req | input | 1 | Wait instruction executed |
| wake_req | input | 1 | Reset-free release: interrupt request |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the mode register, 1 the control register |
| wr_data | input | 8 | Write data |
| rd_sel | input | 1 | 0 reads the mode register, 1 the control register |
| rd_data | output | 8 | Read data of the selected register |
| cpu_ce | output | 1 | CPU clock enable, one cycle per CPU clock |
| main_osc_en | output | 1 | Main oscillator run enable |
| clk_halted | output | 1 | CPU clock gated by wait, stop or stabilisation |

## Verification
A wrong divider count or a divider that is not cleared on a mode write shows on `cpu_ce` within one rate period, which is at most eight ticks. A wrong automatic-switch count or a lost start flag moves the mode field read-back by one or more slow machine cycles. That means tens of cycles of the fast clock. A wrong prescaler preload or count-source phase changes the length of the stabilisation gap on `clk_halted` by at least 16 ticks, and this shows only when the gap ends.

// File: rtl/scm_pkg.sv
`timescale 1ns/1ps
package scm_pkg;
  typedef enum logic [1:0] {
    MODE_HIGH = 2'b00,
    MODE_MID  = 2'b01,
    MODE_LOW  = 2'b10,
    MODE_ALT  = 2'b11
  } speed_t;

  // terminal count of the rate divider for a mode
  function automatic int div_last(speed_t m, int fast_div, int mid_div);
    return (m == MODE_MID || m == MODE_ALT) ? mid_div - 1 : fast_div - 1;
  endfunction

  // machine cycles to wait before the automatic switch completes
  function automatic int wait_load(logic short_sel, int long_n, int short_n);
    return short_sel ? short_n : long_n;
  endfunction
endpackage

// File: rtl/scm_clkdiv.sv
`timescale 1ns/1ps
module scm_clkdiv
  import scm_pkg::*;
#(
  parameter int FAST_DIV = 2,
  parameter int MID_DIV  = 8,
  parameter int CS_DIV   = 16
) (
  input  logic   clk,
  input  logic   rst_n,
  input  speed_t mode,
  input  logic   src_tick,
  input  logic   div_clr,
  input  logic   cs_clr,
  output logic   phi_tick,
  output logic   cs_tick
);
  localparam int CW = $clog2(MID_DIV);
  localparam int SW = $clog2(CS_DIV);

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;
  logic [SW-1:0] scnt;

  assign last     = CW'(div_last(mode, FAST_DIV, MID_DIV));
  assign phi_tick = src_tick && (cnt == last);
  assign cs_tick  = src_tick && (scnt == SW'(CS_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (div_clr)  cnt <= '0;
    else if (src_tick) cnt <= phi_tick ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        scnt <= '0;
    else if (cs_clr)   scnt <= '0;
    else if (src_tick) scnt <= cs_tick ? '0 : scnt + 1'b1;
  end

  // R2: a restarted divider never emits a short first period
  a_r2_no_runt: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(div_clr) && (mode == MODE_MID || mode == MODE_ALT)) |-> !phi_tick);
endmodule

// File: rtl/scm_autosw.sv
`timescale 1ns/1ps
module scm_autosw
  import scm_pkg::*;
#(
  parameter int WAIT_LONG  = 7,
  parameter int WAIT_SHORT = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  input  logic short_sel,
  input  logic phi_tick,
  output logic pending,
  output logic done
);
  localparam int WW = $clog2(WAIT_LONG + 1);

  logic [WW-1:0] cnt;

  assign done = pending && phi_tick && (cnt == WW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
      cnt     <= '0;
    end else if (trig) begin
      pending <= 1'b1;
      cnt     <= WW'(wait_load(short_sel, WAIT_LONG, WAIT_SHORT));
    end else if (done) begin
      pending <= 1'b0;
      cnt     <= '0;
    end else if (pending && phi_tick) begin
      cnt     <= cnt - 1'b1;
    end
  end

  // R6: the wait counter never runs dry while a switch is pending
  a_r6_count_live: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> (cnt != '0));
endmodule

// File: rtl/scm_stoptmr.sv
`timescale 1ns/1ps
module scm_stoptmr #(
  parameter int PSC_W    = 8,
  parameter int PSC_INIT = 255,
  parameter int T1_INIT  = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic skip,
  input  logic active,
  input  logic cs_tick,
  output logic done
);
  logic [PSC_W-1:0] psc;
  logic [PSC_W-1:0] t1;

  assign done = active && cs_tick && (skip || (psc == '0 && t1 == PSC_W'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc <= '0;
      t1  <= '0;
    end else if (load) begin
      psc <= PSC_W'(PSC_INIT);
      t1  <= PSC_W'(T1_INIT);
    end else if (active && cs_tick && !done && !skip) begin
      if (psc == '0) begin
        psc <= PSC_W'(PSC_INIT);
        t1  <= t1 - 1'b1;
      end else begin
        psc <= psc - 1'b1;
      end
    end
  end

  // R9: timer 1 is never exhausted while the preloaded countdown runs
  a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !skip) |-> (t1 != '0));
endmodule

// File: rtl/sysclk_mode_ctrl.sv
`timescale 1ns/1ps
module sysclk_mode_ctrl
  import scm_pkg::*;
#(
  parameter int FAST_DIV   = 2,
  parameter int MID_DIV    = 8,
  parameter int CS_DIV     = 16,
  parameter int PSC_W      = 8,
  parameter int PSC_INIT   = 255,
  parameter int T1_INIT    = 1,
  parameter int WAIT_LONG  = 7,
  parameter int WAIT_SHORT = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       main_tick,
  input  logic       sub_tick,
  input  logic       stop_req,
  input  logic       wait_req,
  input  logic       wake_req,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  input  logic       rd_sel,
  output logic [7:0] rd_data,
  output logic       cpu_ce,
  output logic       main_osc_en,
  output logic       clk_halted
);
  speed_t mode_q;
  logic   mstop_q, skip_q, en_q, wsel_q;
  logic   wait_q, stop_q, rec_q;

  // named internal events
  logic mode_wr, ctrl_wr, halted, src_tick, phi_tick, cs_tick;
  logic sw_trig, sw_pend, sw_done, div_clr;
  logic stop_go, wait_go, stop_release, rec_done;
  logic unused_wr_bit;

  assign mode_wr      = wr_en && !wr_sel;
  assign ctrl_wr      = wr_en && wr_sel;
  assign halted       = wait_q || stop_q || rec_q;
  assign src_tick     = !stop_q && ((mode_q == MODE_LOW) ? sub_tick : (main_tick && !mstop_q));
  assign sw_trig      = ctrl_wr && wr_data[3] && wr_data[1] && (mode_q == MODE_LOW) && !sw_pend;
  assign div_clr      = mode_wr || sw_done;
  assign stop_go      = !halted && stop_req && !wake_req;
  assign wait_go      = !halted && wait_req && !stop_req && !wake_req;
  assign stop_release = stop_q && wake_req;
  assign unused_wr_bit = wr_data[4];

  scm_clkdiv #(.FAST_DIV(FAST_DIV), .MID_DIV(MID_DIV), .CS_DIV(CS_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .mode(mode_q), .src_tick(src_tick),
    .div_clr(div_clr), .cs_clr(stop_go), .phi_tick(phi_tick), .cs_tick(cs_tick)
  );

  scm_autosw #(.WAIT_LONG(WAIT_LONG), .WAIT_SHORT(WAIT_SHORT)) u_sw (
    .clk(clk), .rst_n(rst_n), .trig(sw_trig), .short_sel(wr_data[2]),
    .phi_tick(phi_tick), .pending(sw_pend), .done(sw_done)
  );

  scm_stoptmr #(.PSC_W(PSC_W), .PSC_INIT(PSC_INIT), .T1_INIT(T1_INIT)) u_stab (
    .clk(clk), .rst_n(rst_n), .load(stop_release), .skip(skip_q),
    .active(rec_q), .cs_tick(cs_tick), .done(rec_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_MID;
      mstop_q <= 1'b0;
    end else begin
      if (sw_done) begin
        mode_q <= MODE_MID;
      end else if (mode_wr) begin
        mode_q  <= speed_t'(wr_data[7:6]);
        mstop_q <= wr_data[5];
      end
      if (sw_trig) mstop_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      skip_q <= 1'b0;
      en_q   <= 1'b0;
      wsel_q <= 1'b0;
    end else if (ctrl_wr) begin
      skip_q <= wr_data[0];
      en_q   <= wr_data[1];
      wsel_q <= wr_data[2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q <= 1'b0;
      stop_q <= 1'b0;
      rec_q  <= 1'b0;
    end else begin
      if (wake_req)     wait_q <= 1'b0;
      else if (wait_go) wait_q <= 1'b1;
      if (stop_release) stop_q <= 1'b0;
      else if (stop_go) stop_q <= 1'b1;
      if (stop_release)  rec_q <= 1'b1;
      else if (rec_done) rec_q <= 1'b0;
    end
  end

  assign rd_data     = rd_sel ? {4'b0000, sw_pend, wsel_q, en_q, skip_q}
                              : {mode_q, mstop_q, 5'b00000};
  assign cpu_ce      = phi_tick && !halted;
  assign main_osc_en = !mstop_q && !stop_q;
  assign clk_halted  = halted;

  // R6: a completed switch leaves middle-speed mode and a cleared start flag
  a_r6_lands_mid: assert property (@(posedge clk) disable iff (!rst_n)
    sw_done |=> (mode_q == MODE_MID) && !sw_pend);

  // R11: at most one halt cause is ever active
  a_r11_one_halt: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wait_q, stop_q, rec_q}));
endmodule

// File: tb/sysclk_mode_ctrl_bench.sv
`timescale 1ns/1ps
module sysclk_mode_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic main_tick = 1'b0, sub_tick = 1'b0;
  logic stop_req = 1'b0, wait_req = 1'b0, wake_req = 1'b0;
  logic wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic cpu_ce, main_osc_en, clk_halted;

  always #2 clk = ~clk;

  sysclk_mode_ctrl u_sysclk_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .main_tick(main_tick), .sub_tick(sub_tick),
    .stop_req(stop_req), .wait_req(wait_req), .wake_req(wake_req),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
    .rd_data(rd_data), .cpu_ce(cpu_ce), .main_osc_en(main_osc_en),
    .clk_halted(clk_halted)
  );

  int checks = 0, failures = 0, cyc = 0, ce_cnt = 0;
  bit main_gap = 0, finished = 0;
  string cur_req = "R1";

  // ---------------- behavioural reference ----------------
  int m_mode, m_div, m_cs, m_psc, m_t1, m_wcnt;
  bit m_mstop, m_skip, m_en, m_wsel, m_pend, m_wait, m_stop, m_rec;
  bit t_src, t_phi, t_cs, t_halt, t_mw, t_cw, t_trig, t_done, t_rdone, t_stopgo;

  function automatic bit f_src();
    if (m_stop) return 0;
    return (m_mode == 2) ? sub_tick : (main_tick && !m_mstop);
  endfunction
  function automatic int f_period();
    return (m_mode == 1 || m_mode == 3) ? 8 : 2;
  endfunction
  function automatic bit f_phi();  return f_src() && (m_div == f_period() - 1); endfunction
  function automatic bit f_cs();   return f_src() && (m_cs == 15); endfunction
  function automatic bit f_halt(); return m_wait || m_stop || m_rec; endfunction
  function automatic logic [7:0] f_rd(bit sel);
    if (sel) return {4'h0, m_pend, m_wsel, m_en, m_skip};
    return {m_mode[1:0], m_mstop, 5'h00};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 1; m_div = 0; m_cs = 0; m_psc = 0; m_t1 = 0; m_wcnt = 0;
      m_mstop = 0; m_skip = 0; m_en = 0; m_wsel = 0; m_pend = 0;
      m_wait = 0; m_stop = 0; m_rec = 0;
    end else begin
      t_src = f_src(); t_phi = f_phi(); t_cs = f_cs(); t_halt = f_halt();
      t_mw = wr_en && !wr_sel; t_cw = wr_en && wr_sel;
      t_trig = t_cw && wr_data[3] && wr_data[1] && m_mode == 2 && !m_pend;
      t_done = m_pend && t_phi && m_wcnt == 1;
      t_rdone = m_rec && t_cs && (m_skip || (m_psc == 0 && m_t1 == 1));
      t_stopgo = !t_halt && stop_req && !wake_req;
      if (t_mw || t_done) m_div = 0;
      else if (t_src) m_div = t_phi ? 0 : m_div + 1;
      if (t_stopgo) m_cs = 0;
      else if (t_src) m_cs = (m_cs + 1) % 16;
      if (m_stop && wake_req) begin m_psc = 255; m_t1 = 1; end
      else if (m_rec && t_cs && !t_rdone && !m_skip) begin
        if (m_psc == 0) begin m_psc = 255; m_t1 = m_t1 - 1; end
        else m_psc = m_psc - 1;
      end
      if (t_trig) begin m_pend = 1; m_wcnt = wr_data[2] ? 5 : 7; end
      else if (t_done) begin m_pend = 0; m_wcnt = 0; end
      else if (m_pend && t_phi) m_wcnt = m_wcnt - 1;
      if (t_done) m_mode = 1;
      else if (t_mw) begin m_mode = int'(wr_data[7:6]); m_mstop = wr_data[5]; end
      if (t_trig) m_mstop = 0;
      if (t_cw) begin m_skip = wr_data[0]; m_en = wr_data[1]; m_wsel = wr_data[2]; end
      if (t_rdone) m_rec = 0;
      if (wake_req) begin
        m_wait = 0;
        if (m_stop) begin m_stop = 0; m_rec = 1; end
      end else if (t_stopgo) m_stop = 1;
      else if (!t_halt && wait_req) m_wait = 1;
    end
  end

  // ---------------- checking ----------------
  task automatic chk(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input logic w = 0, input logic s = 0, input logic [7:0] d = 8'h00,
                      input logic sp = 0, input logic wt = 0, input logic wk = 0);
    @(negedge clk);
    cyc++;
    main_tick = main_gap ? cyc[0] : 1'b1;
    sub_tick  = (cyc % 5 == 0);
    wr_en = w; wr_sel = s; wr_data = d;
    stop_req = sp; wait_req = wt; wake_req = wk;
    #1;
    if (rst_n) begin
      chk(cur_req, int'(cpu_ce), int'(f_src() && (m_div == f_period() - 1) && !f_halt()), "cpu_ce");
      chk(cur_req, int'(main_osc_en), int'(!m_mstop && !m_stop), "main_osc_en");
      chk(cur_req, int'(clk_halted), int'(f_halt()), "clk_halted");
      chk(cur_req, int'(rd_data), int'(f_rd(rd_sel)), "rd_data");
    end
    if (cpu_ce) ce_cnt++;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic read_reg(bit sel, output logic [7:0] v);
    rd_sel = sel;
    step();
    v = rd_data;
  endtask

  task automatic halt_len(output int n);
    n = 0;
    step();
    while (clk_halted && n < 10000) begin n++; step(); end
  endtask

  initial begin : watchdog
    #400000;
    if (!finished) begin
      failures++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    logic [7:0] v;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    cur_req = "R1";
    read_reg(0, v); chk("R1", v, 8'h40, "mode reg after reset");
    read_reg(1, v); chk("R1", v, 8'h00, "ctrl reg after reset");
    chk("R1", main_osc_en, 1, "main_osc_en after reset");
    chk("R1", clk_halted, 0, "clk_halted after reset");
    rd_sel = 0;

    // R2 rates
    cur_req = "R2";
    step(1, 0, 8'h40); ce_cnt = 0; idle(80); chk("R2", ce_cnt, 10, "middle pulses/80");
    step(1, 0, 8'h00); ce_cnt = 0; idle(80); chk("R2", ce_cnt, 40, "high pulses/80");
    step(1, 0, 8'hC0); ce_cnt = 0; idle(80); chk("R2", ce_cnt, 10, "code11 pulses/80");
    main_gap = 1;
    step(1, 0, 8'h00); ce_cnt = 0; idle(80); chk("R2", ce_cnt, 20, "high sparse ticks/80");
    main_gap = 0;

    // R5 start refused outside low-speed mode
    cur_req = "R5";
    step(1, 1, 8'h0A);
    read_reg(1, v); chk("R5", v, 8'h02, "start outside low mode");
    rd_sel = 0;

    // R3 low mode with main oscillator stopped
    cur_req = "R3";
    step(1, 0, 8'hA0);
    read_reg(0, v); chk("R3", v, 8'hA0, "mode reg low+stop");
    chk("R3", main_osc_en, 0, "main_osc_en with stop bit");
    cur_req = "R2";
    ce_cnt = 0; idle(100); chk("R2", ce_cnt, 10, "low pulses/100");

    // R5 start without enable
    cur_req = "R5";
    step(1, 1, 8'h08);
    read_reg(1, v); chk("R5", v, 8'h00, "start without enable");
    read_reg(0, v); chk("R5", v, 8'hA0, "mode unchanged by refused start");

    // R6 automatic switch, long wait
    cur_req = "R6";
    step(1, 1, 8'h0A);
    read_reg(1, v); chk("R6", v, 8'h0A, "start flag set");
    chk("R6", main_osc_en, 1, "oscillator restarted");
    rd_sel = 0;
    idle(58);
    chk("R6", rd_data, 8'h80, "still low at 60 steps");
    idle(15);
    chk("R6", rd_data, 8'h40, "middle after long wait");
    read_reg(1, v); chk("R4", v, 8'h02, "ctrl after switch");

    // R6 short wait
    rd_sel = 0;
    step(1, 0, 8'h80);
    step(1, 1, 8'h0E);
    idle(39);
    chk("R6", rd_data, 8'h80, "still low at 40 steps");
    idle(15);
    chk("R6", rd_data, 8'h40, "middle after short wait");
    read_reg(1, v); chk("R4", v, 8'h06, "ctrl fields after short switch");
    rd_sel = 0;

    // R7 wait
    cur_req = "R7";
    step(0, 0, 8'h00, 0, 1);
    ce_cnt = 0; idle(40);
    chk("R7", ce_cnt, 0, "pulses during wait");
    chk("R7", main_osc_en, 1, "oscillator during wait");
    chk("R7", clk_halted, 1, "halted during wait");
    // R11 stop ignored while waiting
    cur_req = "R11";
    step(0, 0, 8'h00, 1);
    idle(3);
    chk("R11", main_osc_en, 1, "stop ignored while halted");
    cur_req = "R7";
    step(0, 0, 8'h00, 0, 0, 1);
    ce_cnt = 0; idle(80); chk("R7", ce_cnt, 10, "pulses after wake");

    // R8 / R9 stop with full stabilisation
    cur_req = "R8";
    step(1, 1, 8'h00);
    step(0, 0, 8'h00, 1);
    step();
    chk("R8", main_osc_en, 0, "oscillator in stop");
    chk("R8", clk_halted, 1, "halted in stop");
    ce_cnt = 0; idle(50); chk("R8", ce_cnt, 0, "pulses in stop");
    cur_req = "R9";
    step(0, 0, 8'h00, 0, 0, 1);
    halt_len(n);
    chk("R9", n, 4096, "stabilisation length preload");

    // R10 stop with preload skipped
    cur_req = "R10";
    step(1, 1, 8'h01);
    step(0, 0, 8'h00, 1);
    idle(20);
    step(0, 0, 8'h00, 0, 0, 1);
    halt_len(n);
    chk("R10", n, 16, "stabilisation length skipped");
    idle(20);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule